// File: doc/BRIEF.md
# Pipeline Hazard and Stall Controller

This block is the control unit for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the opcode held in the decode, execute, memory and writeback stages, at the branch outcome the execute stage computes, and at the register numbers involved in a load followed by a dependent instruction. From these it decides which pipeline registers hold their contents (stall), which are loaded with a no-op (bubble), and where the next instruction is fetched from. The registers, arithmetic and memory are outside the block; it drives only control.

Conditional jumps are always guessed taken. When execute reports the jump was not taken, the two younger instructions are squashed and fetch is redirected to the fallthrough address. A return instruction freezes fetch while it moves through decode, execute and memory, and fetch resumes from the return address when the return reaches writeback. A load whose result the next instruction needs costs one held cycle. A halt stops new fetching as soon as it is decoded, lets everything older finish, and then freezes the machine.

A small state machine follows the halt. RUN is normal operation; RUN goes to DRAIN when a halt sits in decode and no misprediction, load-use hold or return freeze is active that cycle. DRAIN keeps fetch stalled and feeds bubbles behind the halt; DRAIN goes to HALTED when the halt reaches writeback. HALTED holds every stage and is left only by reset.

Top module: `hz_ctrl`

## Requirements
- R1: After reset the state is RUN, `halted` is 0, and with every stage holding NOP (opcode 0) all five controls are 0, `pc_sel` is 0 and `fetch_pc` equals `pred_pc`.
- R2: With no hazard present (e.g. ALU opcode 2 in every stage), no stall or bubble is raised and `fetch_pc` follows `pred_pc` (`pc_sel` 0).
- R3: A conditional jump (opcode 5) in execute with `e_cnd` 0 raises `d_bubble` and `e_bubble`, no stall, and selects the fallthrough (`pc_sel` 1, `fetch_pc` = `fall_pc`); with `e_cnd` 1 it has no effect.
- R4: A return (opcode 6) in decode, execute or memory raises `f_stall` and `d_bubble` without `d_stall`, so three bubbles follow each return.
- R5: A return in writeback selects the return address (`pc_sel` 2, `fetch_pc` = `ret_pc`).
- R6: A load (opcode 3) in execute whose destination is not 15 (the no-register code) and equals `d_src_a` or `d_src_b` raises `f_stall`, `d_stall` and `e_bubble`; a destination of 15, no match, or a non-load opcode raises nothing.
- R7: A misprediction overrides a simultaneous load-use hold or return freeze: only `d_bubble`, `e_bubble` and the fallthrough select result.
- R8: A load-use hold together with a return in decode holds decode (`d_stall` 1, `d_bubble` 0).
- R9: A halt (opcode 1) in decode raises `f_stall` and `d_bubble`; in DRAIN these stay raised each cycle, and `w_stall` rises when the halt is in writeback.
- R10: One cycle after the halt sits in writeback, `halted` is 1 and `f_stall`, `d_stall`, `e_bubble`, `w_stall` stay 1 (`d_bubble` 0, `pc_sel` 0) whatever the inputs, until reset.
- R11: A halt in decode squashed by a misprediction does not start draining: the next cycle with idle stages shows no control raised.
- R12: `d_stall` and `d_bubble` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_op | input | 4 | Opcode in decode |
| e_op | input | 4 | Opcode in execute |
| m_op | input | 4 | Opcode in memory |
| w_op | input | 4 | Opcode in writeback |
| e_cnd | input | 1 | Jump taken outcome from execute |
| d_src_a | input | 4 | First source register of decode |
| d_src_b | input | 4 | Second source register of decode |
| e_dst_mem | input | 4 | Load destination register in execute |
| pred_pc | input | 64 | Predicted next fetch address |
| fall_pc | input | 64 | Fallthrough address of the jump in execute |
| ret_pc | input | 64 | Return address from writeback |
| f_stall | output | 1 | Hold fetch register |
| d_stall | output | 1 | Hold decode register |
| d_bubble | output | 1 | Load no-op into decode register |
| e_bubble | output | 1 | Load no-op into execute register |
| w_stall | output | 1 | Hold writeback register |
| pc_sel | output | 2 | Fetch source: 0 predicted, 1 fallthrough, 2 return |
| fetch_pc | output | 64 | Selected fetch address |
| halted | output | 1 | Machine frozen after halt |

## Verification
The checker watches every cycle that decode is never both held and bubbled, that a not-taken jump in execute always yields the two bubbles and the fallthrough select, that a matching load in execute always holds fetch and decode, that a halt in writeback holds writeback, and that `halted` never clears without reset. Only the bench's scenarios can show the halt drain sequence stage by stage, the squashed halt leaving the machine running, the exact priority outcomes when hazards coincide, and that inputs are ignored once halted.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int OP_W  = 4;
    localparam int REG_W = 4;

    localparam logic [OP_W-1:0] OP_NOP   = 4'h0;
    localparam logic [OP_W-1:0] OP_HALT  = 4'h1;
    localparam logic [OP_W-1:0] OP_ALU   = 4'h2;
    localparam logic [OP_W-1:0] OP_LOAD  = 4'h3;
    localparam logic [OP_W-1:0] OP_STORE = 4'h4;
    localparam logic [OP_W-1:0] OP_JCC   = 4'h5;
    localparam logic [OP_W-1:0] OP_RET   = 4'h6;

    localparam logic [REG_W-1:0] REG_NONE = '1;

    localparam logic [1:0] SEL_PRED = 2'd0;
    localparam logic [1:0] SEL_FALL = 2'd1;
    localparam logic [1:0] SEL_RET  = 2'd2;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_HALTED = 2'd2
    } hz_state_e;
endpackage

// File: rtl/hz_detect.sv
module hz_detect
    import hz_pkg::*;
#(
    parameter int NSRC = 2
) (
    input  logic [OP_W-1:0]             d_op,
    input  logic [OP_W-1:0]             e_op,
    input  logic [OP_W-1:0]             m_op,
    input  logic                        e_cnd,
    input  logic [NSRC-1:0][REG_W-1:0]  d_srcs,
    input  logic [REG_W-1:0]            e_dst,
    output logic                        mispredict,
    output logic                        load_use,
    output logic                        ret_busy,
    output logic                        halt_dec
);
    localparam int NRET = 3;

    logic [NRET-1:0][OP_W-1:0] ret_ops;
    logic [NRET-1:0]           ret_hit;
    logic [NSRC-1:0]           src_hit;

    assign ret_ops = {m_op, e_op, d_op};

    generate
        for (genvar s = 0; s < NRET; s++) begin : g_ret
            assign ret_hit[s] = (ret_ops[s] == OP_RET);
        end
        for (genvar k = 0; k < NSRC; k++) begin : g_src
            assign src_hit[k] = (d_srcs[k] == e_dst);
        end
    endgenerate

    always_comb begin
        mispredict = (e_op == OP_JCC) && !e_cnd;
        load_use   = (e_op == OP_LOAD) && (e_dst != REG_NONE) && (|src_hit);
        ret_busy   = |ret_hit;
        halt_dec   = (d_op == OP_HALT);
    end
endmodule

// File: rtl/hz_fsm.sv
module hz_fsm
    import hz_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      halt_enter,
    input  logic      halt_at_wb,
    output hz_state_e state
);
    hz_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:    if (halt_enter) state_nx = ST_DRAIN;
            ST_DRAIN:  if (halt_at_wb) state_nx = ST_HALTED;
            ST_HALTED: state_nx = ST_HALTED;
            default:   state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end
endmodule

// File: rtl/hz_pcsel.sv
module hz_pcsel
    import hz_pkg::*;
#(
    parameter int PC_W = 64
) (
    input  logic [1:0]      sel,
    input  logic [PC_W-1:0] pred_pc,
    input  logic [PC_W-1:0] fall_pc,
    input  logic [PC_W-1:0] ret_pc,
    output logic [PC_W-1:0] fetch_pc
);
    always_comb begin
        unique case (sel)
            SEL_FALL: fetch_pc = fall_pc;
            SEL_RET:  fetch_pc = ret_pc;
            default:  fetch_pc = pred_pc;
        endcase
    end
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
    import hz_pkg::*;
#(
    parameter int PC_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       d_op,
    input  logic [3:0]       e_op,
    input  logic [3:0]       m_op,
    input  logic [3:0]       w_op,
    input  logic             e_cnd,
    input  logic [3:0]       d_src_a,
    input  logic [3:0]       d_src_b,
    input  logic [3:0]       e_dst_mem,
    input  logic [PC_W-1:0]  pred_pc,
    input  logic [PC_W-1:0]  fall_pc,
    input  logic [PC_W-1:0]  ret_pc,
    output logic             f_stall,
    output logic             d_stall,
    output logic             d_bubble,
    output logic             e_bubble,
    output logic             w_stall,
    output logic [1:0]       pc_sel,
    output logic [PC_W-1:0]  fetch_pc,
    output logic             halted
);
    logic      mispredict, load_use, ret_busy, halt_dec;
    logic      halt_enter, halt_at_wb;
    hz_state_e state;

    hz_detect #(.NSRC(2)) u_detect (
        .d_op       (d_op),
        .e_op       (e_op),
        .m_op       (m_op),
        .e_cnd      (e_cnd),
        .d_srcs     ({d_src_b, d_src_a}),
        .e_dst      (e_dst_mem),
        .mispredict (mispredict),
        .load_use   (load_use),
        .ret_busy   (ret_busy),
        .halt_dec   (halt_dec)
    );

    assign halt_enter = halt_dec && !mispredict && !load_use && !ret_busy;
    assign halt_at_wb = (w_op == OP_HALT);

    hz_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_enter (halt_enter),
        .halt_at_wb (halt_at_wb),
        .state      (state)
    );

    // Output decode: priority mispredict > load-use > return > halt.
    always_comb begin
        f_stall  = 1'b0;
        d_stall  = 1'b0;
        d_bubble = 1'b0;
        e_bubble = 1'b0;
        w_stall  = 1'b0;
        pc_sel   = SEL_PRED;
        halted   = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (mispredict) begin
                    d_bubble = 1'b1;
                    e_bubble = 1'b1;
                    pc_sel   = SEL_FALL;
                end else begin
                    if (load_use) begin
                        f_stall  = 1'b1;
                        d_stall  = 1'b1;
                        e_bubble = 1'b1;
                    end else if (ret_busy || halt_dec) begin
                        f_stall  = 1'b1;
                        d_bubble = 1'b1;
                    end
                    if (w_op == OP_RET) pc_sel = SEL_RET;
                end
            end
            ST_DRAIN: begin
                f_stall  = 1'b1;
                d_bubble = 1'b1;
                w_stall  = halt_at_wb;
            end
            ST_HALTED: begin
                f_stall  = 1'b1;
                d_stall  = 1'b1;
                e_bubble = 1'b1;
                w_stall  = 1'b1;
                halted   = 1'b1;
            end
            default: begin
                f_stall = 1'b1;
            end
        endcase
    end

    hz_pcsel #(.PC_W(PC_W)) u_pcsel (
        .sel      (pc_sel),
        .pred_pc  (pred_pc),
        .fall_pc  (fall_pc),
        .ret_pc   (ret_pc),
        .fetch_pc (fetch_pc)
    );
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk
    import hz_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] d_op,
    input logic [3:0] e_op,
    input logic [3:0] w_op,
    input logic       e_cnd,
    input logic [3:0] d_src_a,
    input logic [3:0] d_src_b,
    input logic [3:0] e_dst_mem,
    input logic       f_stall,
    input logic       d_stall,
    input logic       d_bubble,
    input logic       e_bubble,
    input logic       w_stall,
    input logic [1:0] pc_sel,
    input logic       halted
);
    logic not_taken, dep_load;
    assign not_taken = (e_op == OP_JCC) && !e_cnd;
    assign dep_load  = (e_op == OP_LOAD) && (e_dst_mem != REG_NONE) &&
                       ((e_dst_mem == d_src_a) || (e_dst_mem == d_src_b));

    assert_no_dual_d_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(d_stall && d_bubble));

    assert_mispredict_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (not_taken && !halted) |-> (d_bubble && e_bubble && !f_stall && pc_sel == SEL_FALL));

    assert_load_use_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dep_load && !not_taken) |-> (f_stall && d_stall && e_bubble));

    assert_ret_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (d_op == OP_RET && !not_taken) |-> f_stall);

    assert_wb_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (w_op == OP_HALT) |-> w_stall);

    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
endmodule

bind hz_ctrl hz_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .d_op      (d_op),
    .e_op      (e_op),
    .w_op      (w_op),
    .e_cnd     (e_cnd),
    .d_src_a   (d_src_a),
    .d_src_b   (d_src_b),
    .e_dst_mem (e_dst_mem),
    .f_stall   (f_stall),
    .d_stall   (d_stall),
    .d_bubble  (d_bubble),
    .e_bubble  (e_bubble),
    .w_stall   (w_stall),
    .pc_sel    (pc_sel),
    .halted    (halted)
);

// File: tb/tb_hz_ctrl.sv
module tb_hz_ctrl;
    localparam logic [3:0] NOP = 4'h0, HALT = 4'h1, ALU = 4'h2, LOAD = 4'h3,
                           JCC = 4'h5, RET = 4'h6;
    localparam logic [63:0] PRED = 64'h1000, FALL = 64'h2000, RADDR = 64'h3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  d_op, e_op, m_op, w_op, d_src_a, d_src_b, e_dst_mem;
    logic        e_cnd;
    logic [63:0] pred_pc, fall_pc, ret_pc, fetch_pc;
    logic        f_stall, d_stall, d_bubble, e_bubble, w_stall, halted;
    logic [1:0]  pc_sel;
    int          n_cmp = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;

    hz_ctrl dut (.*);

    wire [4:0] ctl = {f_stall, d_stall, d_bubble, e_bubble, w_stall};

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        d_op = NOP; e_op = NOP; m_op = NOP; w_op = NOP; e_cnd = 1'b1;
        d_src_a = 4'hF; d_src_b = 4'hF; e_dst_mem = 4'hF;
        pred_pc = PRED; fall_pc = FALL; ret_pc = RADDR;
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        do_reset();
        #2;
        check("R1 controls", ctl, 5'b00000);
        check("R1 pc_sel", pc_sel, 0);
        check("R1 fetch_pc", fetch_pc, PRED);
        check("R1 halted", halted, 0);
    endtask

    task automatic t_normal();
        idle(); d_op = ALU; e_op = ALU; m_op = ALU; w_op = ALU;
        d_src_a = 4'd2; e_dst_mem = 4'd2;
        #2;
        check("R2 alu stream", ctl, 5'b00000);
        check("R2 fetch_pc", fetch_pc, PRED);
        idle(); e_op = JCC; e_cnd = 1'b1;
        #2;
        check("R3 taken jump ctl", ctl, 5'b00000);
        check("R3 taken jump pc", fetch_pc, PRED);
        tick();
    endtask

    task automatic t_mispredict();
        idle(); e_op = JCC; e_cnd = 1'b0;
        #2;
        check("R3 mispredict ctl", ctl, 5'b00110);
        check("R3 mispredict sel", pc_sel, 1);
        check("R3 mispredict pc", fetch_pc, FALL);
        tick();
    endtask

    task automatic t_ret();
        idle(); d_op = RET; #2; check("R4 ret in decode", ctl, 5'b10100);
        tick();
        idle(); e_op = RET; #2; check("R4 ret in execute", ctl, 5'b10100);
        tick();
        idle(); m_op = RET; #2; check("R4 ret in memory", ctl, 5'b10100);
        tick();
        idle(); w_op = RET; #2;
        check("R5 ret in wb ctl", ctl, 5'b00000);
        check("R5 ret sel", pc_sel, 2);
        check("R5 ret pc", fetch_pc, RADDR);
        tick();
    endtask

    task automatic t_load_use();
        idle(); e_op = LOAD; e_dst_mem = 4'd4; d_src_a = 4'd4;
        #2; check("R6 match src a", ctl, 5'b11010);
        d_src_a = 4'd1; d_src_b = 4'd4;
        #2; check("R6 match src b", ctl, 5'b11010);
        d_src_b = 4'd5;
        #2; check("R6 no match", ctl, 5'b00000);
        e_dst_mem = 4'hF; d_src_a = 4'hF;
        #2; check("R6 none register", ctl, 5'b00000);
        e_op = ALU; e_dst_mem = 4'd4; d_src_a = 4'd4;
        #2; check("R6 non-load", ctl, 5'b00000);
        tick();
    endtask

    task automatic t_priority();
        idle(); e_op = JCC; e_cnd = 1'b0; d_op = RET;
        #2; check("R7 mispredict over ret", ctl, 5'b00110);
        check("R7 mispredict over ret pc", fetch_pc, FALL);
        tick();
        idle(); e_op = LOAD; e_dst_mem = 4'd7; d_src_b = 4'd7; d_op = RET;
        #2; check("R8 load-use over ret", ctl, 5'b11010);
        tick();
    endtask

    task automatic t_halt();
        idle(); d_op = HALT;
        #2; check("R9 halt in decode", ctl, 5'b10100);
        tick(); idle(); e_op = HALT;
        #2; check("R9 drain halt in execute", ctl, 5'b10100);
        check("R9 not halted yet", halted, 0);
        tick(); idle(); m_op = HALT;
        #2; check("R9 drain halt in memory", ctl, 5'b10100);
        tick(); idle(); w_op = HALT;
        #2; check("R9 halt in wb", ctl, 5'b10101);
        check("R9 halted still 0", halted, 0);
        tick();
        #2; check("R10 halted flag", halted, 1);
        check("R10 frozen ctl", ctl, 5'b11011);
        idle(); e_op = JCC; e_cnd = 1'b0; d_op = RET;
        #2; check("R10 inputs ignored ctl", ctl, 5'b11011);
        check("R10 inputs ignored sel", pc_sel, 0);
        tick(); tick();
        check("R10 stays halted", halted, 1);
        do_reset();
        #2; check("R1 reset clears halt", halted, 0);
    endtask

    task automatic t_squash();
        idle(); d_op = HALT; e_op = JCC; e_cnd = 1'b0;
        #2; check("R11 squash cycle", ctl, 5'b00110);
        tick(); idle();
        #2; check("R11 no drain", ctl, 5'b00000);
        check("R11 not halted", halted, 0);
        tick();
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_normal();
        t_mispredict();
        t_ret();
        t_load_use();
        t_priority();
        t_squash();
        t_halt();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule